// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the status byte of a serial EEPROM and rules on every write that the command layer wants to start. It holds a sticky status-lock bit, a two-bit protection code and a write enable latch. It reports the busy flag that the write engine supplies. The command decoder raises latch set and clear requests. It hands status-write bytes and array-write addresses to the block over two valid/ready channels. One cycle after a handshake it gets back a pulse saying whether the write is allowed, and a pulse telling the write engine to start a write cycle.

Both request channels stall while a write cycle is in progress: `sw_ready` and `aw_ready` are low while `busy` is high. A source that raises valid keeps valid and its payload unchanged until ready is seen high at a clock edge. A transfer takes place on the rising clock edge where valid and ready are both high. When both channels present a request in the same cycle, the status write goes first, and the array channel is held off (`aw_ready` low) for that cycle. The lock bit and the protection code stand in for non-volatile cells, so they reset to zero.

Top module: `nvm_status_guard`

## Requirements
- R1: `status_rd` reads bit 7 = lock bit, bits 6..4 = 0, bits 3..2 = protection code, bit 1 = write enable latch, and bit 0 = the `busy` input.
- R2: After reset the lock bit, the protection code and the write enable latch are all 0, and both ready outputs are high while `busy` is low.
- R3: A `wel_set` pulse sets the latch and a `wel_clr` pulse clears it, starting with the next cycle. When both are high in the same cycle, clear wins.
- R4: A `cycle_done` pulse clears the latch, starting with the next cycle.
- R5: An accepted status write made while the latch is 1 and the block is not frozen copies data bit 7 to the lock bit and data bits 3..2 to the protection code. Other data bits have no effect. One cycle later it gives `sw_ok` and `cycle_start`, and the latch stays 1 until `cycle_done`.
- R6: A status write made while the latch is 0 gives `sw_drop`, with no `cycle_start`, and changes nothing.
- R7: The block is frozen while the lock bit is 1 and `wp_n` is low, whichever of the two became true first. A status write made while frozen gives `sw_drop` and no `cycle_start`. It changes neither the lock bit nor the protection code, and the latch stays 1.
- R8: Driving `wp_n` high ends the frozen state, and status writes are then accepted again.
- R9: An array write to a 12-bit address is protected according to the protection code. Code 00 protects nothing, 01 protects 0xC00–0xFFF, 10 protects 0x800–0xFFF, and 11 protects every address.
- R10: A write to the identification page (`aw_id` = 1) is protected only under code 11.
- R11: An array write made while the latch is 1 gives `aw_grant` and `cycle_start` if the target is not protected. If the target is protected it gives `aw_deny`, with no `cycle_start`, and the latch clears. With the latch at 0 the write gives `aw_deny` and the latch stays 0.
- R12: While `busy` is high neither channel is ready. When both channels are valid, `aw_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wel_set | input | 1 | Request to set the write enable latch |
| wel_clr | input | 1 | Request to clear the write enable latch |
| cycle_done | input | 1 | Pulse: the write cycle has completed |
| busy | input | 1 | Write cycle in progress |
| wp_n | input | 1 | Write-protect pin level, low = protect |
| sw_valid | input | 1 | Status write request valid |
| sw_ready | output | 1 | Status write channel ready |
| sw_data | input | 8 | Status write byte |
| sw_ok | output | 1 | Pulse: status write applied |
| sw_drop | output | 1 | Pulse: status write discarded |
| aw_valid | input | 1 | Array write query valid |
| aw_ready | output | 1 | Array write channel ready |
| aw_addr | input | 12 | Array byte address |
| aw_id | input | 1 | Target is the identification page |
| aw_grant | output | 1 | Pulse: array write allowed |
| aw_deny | output | 1 | Pulse: array write refused |
| cycle_start | output | 1 | Pulse: start a write cycle |
| status_rd | output | 8 | Status byte for reads |

## Verification
A wrong protection code or lock bit shows up first in `status_rd`, in the cycle after the status write that set it. It also shows up on the next array query as a grant where a deny belongs, or the reverse, one cycle after the handshake. A latch left set where it should have cleared shows as bit 1 of `status_rd` in the next cycle, and it lets a later write through without a fresh `wel_set`. Freeze errors appear on the next status write as `sw_ok` where `sw_drop` is expected, or the reverse, together with a changed or unchanged status byte.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  localparam int SR_W      = 8;
  localparam int POS_LOCK  = 7;
  localparam int POS_BP_HI = 3;
  localparam int POS_BP_LO = 2;
  localparam int POS_WEL   = 1;
  localparam int POS_BUSY  = 0;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_e;
endpackage

// File: rtl/nsg_wel.sv
module nsg_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end
endmodule

// File: rtl/nsg_range.sv
module nsg_range
  import nsg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  prot_e             code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              id_i,
  output logic              hit_o
);
  localparam int MSB = ADDR_W - 1;

  // top quarter: two MSBs set; top half: MSB set
  logic in_quarter;
  logic in_half;
  assign in_quarter = addr_i[MSB] & addr_i[MSB-1];
  assign in_half    = addr_i[MSB];

  always_comb begin
    unique case (code_i)
      PROT_NONE:    hit_o = 1'b0;
      PROT_QUARTER: hit_o = !id_i && in_quarter;
      PROT_HALF:    hit_o = !id_i && in_half;
      default:      hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/nsg_nvbits.sv
module nsg_nvbits
  import nsg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_i,
  input  logic  lock_d,
  input  prot_e code_d,
  output logic  lock_o,
  output prot_e code_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_o <= 1'b0;
      code_o <= PROT_NONE;
    end else if (we_i) begin
      lock_o <= lock_d;
      code_o <= code_d;
    end
  end
endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard
  import nsg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              cycle_done,
  input  logic              busy,
  input  logic              wp_n,
  input  logic              sw_valid,
  output logic              sw_ready,
  input  logic [SR_W-1:0]   sw_data,
  output logic              sw_ok,
  output logic              sw_drop,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              aw_id,
  output logic              aw_grant,
  output logic              aw_deny,
  output logic              cycle_start,
  output logic [SR_W-1:0]   status_rd
);
  logic  wel;
  logic  lock;
  prot_e code;
  logic  hit;

  logic sw_fire, aw_fire, frozen;
  logic sw_apply, aw_pass, aw_kill;

  assign sw_ready = !busy;
  assign aw_ready = !busy && !sw_valid;
  assign sw_fire  = sw_valid && sw_ready;
  assign aw_fire  = aw_valid && aw_ready;

  // lock bit together with pin low freezes the status byte
  assign frozen   = lock && !wp_n;
  assign sw_apply = sw_fire && wel && !frozen;
  assign aw_pass  = aw_fire && wel && !hit;
  assign aw_kill  = aw_fire && wel && hit;

  nsg_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wel_set),
    .clr_i (wel_clr || cycle_done || aw_kill),
    .wel_o (wel)
  );

  nsg_nvbits u_nv (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (sw_apply),
    .lock_d (sw_data[POS_LOCK]),
    .code_d (prot_e'(sw_data[POS_BP_HI:POS_BP_LO])),
    .lock_o (lock),
    .code_o (code)
  );

  nsg_range #(.ADDR_W(ADDR_W)) u_range (
    .code_i (code),
    .addr_i (aw_addr),
    .id_i   (aw_id),
    .hit_o  (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_ok       <= 1'b0;
      sw_drop     <= 1'b0;
      aw_grant    <= 1'b0;
      aw_deny     <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      sw_ok       <= sw_apply;
      sw_drop     <= sw_fire && !sw_apply;
      aw_grant    <= aw_pass;
      aw_deny     <= aw_fire && !aw_pass;
      cycle_start <= sw_apply || aw_pass;
    end
  end

  assign status_rd = {lock, 3'b000, code, wel, busy};
endmodule

// File: rtl/nvm_status_guard_chk.sv
module nvm_status_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cycle_done,
  input logic        wp_n,
  input logic        sw_valid,
  input logic        sw_ready,
  input logic        sw_ok,
  input logic        aw_valid,
  input logic        aw_ready,
  input logic        aw_id,
  input logic        aw_grant,
  input logic        aw_deny,
  input logic        cycle_start,
  input logic [7:0]  status_rd
);
  assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd[6:4] == 3'b000);

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !status_rd[1]);

  assert_ok_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ok |-> cycle_start);

  assert_frozen_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && sw_ready && status_rd[7] && !wp_n)
      |=> !sw_ok && !cycle_start && $stable(status_rd[7:2]));

  assert_id_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready && aw_id && status_rd[3:2] == 2'b11) |=> aw_deny);

  assert_grant_needs_wel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    aw_grant |-> $past(status_rd[1]));

  assert_verdict_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(aw_grant && aw_deny));

  assert_sw_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |-> !aw_ready);
endmodule

bind nvm_status_guard nvm_status_guard_chk u_chk (.*);

// File: tb/nvm_status_guard_bench.sv
module nvm_status_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wel_set = 0, wel_clr = 0, cycle_done = 0, busy = 0, wp_n = 1;
  logic sw_valid = 0, aw_valid = 0, aw_id = 0;
  logic [7:0]  sw_data = 0;
  logic [11:0] aw_addr = 0;
  logic sw_ready, sw_ok, sw_drop, aw_ready, aw_grant, aw_deny, cycle_start;
  logic [7:0] status_rd;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nvm_status_guard u_nvm_status_guard (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_wel();
    wel_set = 1; tick(); wel_set = 0;
  endtask

  task automatic finish_cycle();
    cycle_done = 1; tick(); cycle_done = 0;
  endtask

  task automatic sw(input logic [7:0] d);
    sw_valid = 1; sw_data = d; tick(); sw_valid = 0;
  endtask

  task automatic aw(input logic [11:0] a, input logic id);
    aw_valid = 1; aw_addr = a; aw_id = id; tick(); aw_valid = 0; aw_id = 0;
  endtask

  task automatic set_code(input int c);
    set_wel(); sw(8'(c << 2)); finish_cycle();
  endtask

  function automatic bit prot(input int c, input int a, input bit id);
    if (c == 3) return 1;
    if (id) return 0;
    if (c == 2) return a >= 2048;
    if (c == 1) return a >= 3072;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1; tick();
    chk("R2 status after reset", status_rd, 8'h00);
    chk("R2 sw_ready", sw_ready, 1);
    chk("R2 aw_ready", aw_ready, 1);

    // R3 latch set / clear / clear wins
    set_wel();
    chk("R3 set", status_rd, 8'h02);
    wel_clr = 1; tick(); wel_clr = 0;
    chk("R3 clr", status_rd, 8'h00);
    set_wel();
    wel_set = 1; wel_clr = 1; tick(); wel_set = 0; wel_clr = 0;
    chk("R3 clear wins", status_rd, 8'h00);

    // R6 status write without latch
    sw(8'h8C);
    chk("R6 drop", sw_drop, 1);
    chk("R6 no ok", sw_ok, 0);
    chk("R6 no start", cycle_start, 0);
    chk("R6 status", status_rd, 8'h00);

    // R5 extra data bits ignored, R4 done clears
    set_wel(); sw(8'h7F);
    chk("R5 ok", sw_ok, 1);
    chk("R5 start", cycle_start, 1);
    chk("R5 status", status_rd, 8'h0E);
    finish_cycle();
    chk("R4 done clears", status_rd, 8'h0C);
    set_code(0);
    chk("R5 code back to 0", status_rd, 8'h00);

    // R1 busy bit, R12 stall
    busy = 1; tick();
    chk("R1 busy bit", status_rd, 8'h01);
    chk("R12 sw_ready busy", sw_ready, 0);
    chk("R12 aw_ready busy", aw_ready, 0);
    busy = 0; sw_valid = 1; sw_data = 0; aw_valid = 1; #1;
    chk("R12 aw held by sw", aw_ready, 0);
    tick(); sw_valid = 0; aw_valid = 0;
    chk("R12 array not taken", aw_deny | aw_grant, 0);

    // R7: lock first, then pin low
    set_wel(); sw(8'h84); finish_cycle();
    chk("R5 lock set", status_rd, 8'h84);
    wp_n = 0; set_wel(); sw(8'h00);
    chk("R7 drop", sw_drop, 1);
    chk("R7 no start", cycle_start, 0);
    chk("R7 status frozen wel kept", status_rd, 8'h86);
    // R8 pin high releases
    wp_n = 1; tick(); sw(8'h00);
    chk("R8 ok", sw_ok, 1);
    chk("R8 status", status_rd, 8'h02);
    finish_cycle();
    chk("R8 after done", status_rd, 8'h00);
    // R7: pin low first, then lock
    wp_n = 0; set_wel(); sw(8'h88);
    chk("R7 allowed while unlocked", sw_ok, 1);
    finish_cycle();
    set_wel(); sw(8'h00);
    chk("R7 drop pin-first", sw_drop, 1);
    chk("R7 status pin-first", status_rd, 8'h8A);
    wp_n = 1; tick(); sw(8'h00); finish_cycle();
    chk("R8 cleared", status_rd, 8'h00);

    // R11 array write without latch
    aw(12'h000, 0);
    chk("R11 deny no wel", aw_deny, 1);
    chk("R11 no start", cycle_start, 0);
    chk("R11 wel still 0", status_rd[1], 0);

    // R9 / R10 / R11 sweep over every code and address
    for (int c = 0; c < 4; c++) begin
      set_code(c);
      chk("R9 code loaded", status_rd, c << 2);
      for (int a = 0; a < 4096; a++) begin
        bit p;
        p = prot(c, a, 0);
        set_wel(); aw(12'(a), 0);
        chk("R9 grant", aw_grant, !p);
        chk("R9 deny", aw_deny, p);
        chk("R11 start", cycle_start, !p);
        if (!p) begin
          chk("R11 wel held", status_rd[1], 1);
          finish_cycle();
        end
        chk("R11 wel cleared", status_rd[1], 0);
      end
      set_wel(); aw(12'h000, 1);
      chk("R10 id grant", aw_grant, c != 3);
      chk("R10 id deny", aw_deny, c == 3);
      if (c != 3) finish_cycle();
      chk("R10 wel cleared", status_rd[1], 0);
    end
    set_code(0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule